// File: doc/BRIEF.md
# Semiring Outer-Product Accumulator

This block holds a square tile of signed accumulators and updates all of them at once from a pair of short vectors. Every command carries a column vector and a row vector. An update pairs column element i with row element j through a "combine" operator and folds the result into accumulator (i, j) with a "reduce" operator. Issuing k updates in a row builds a rank-k update of the tile.

The operator pair is a semiring chosen at run time. Ordinary multiply-accumulate, shortest-path style min-plus, longest-path style max-plus and boolean reachability (AND then OR) all share the same registers. Two commands set the tile to a known start state and latch the semiring. One zeroes the tile. The other fills it with the identity of the reduce operator, so that a min-plus or max-plus sweep can start from infinity. A read command streams the tile out one row per beat.

Commands arrive on a valid/ready stream. The block refuses new commands (`in_ready` low) for as long as a readout is in flight, so the tile cannot change underneath a row that is being read. The readout is a valid/ready stream as well. While `out_valid` is high and `out_ready` is low, the row and the last flag are held unchanged and the row pointer stays where it is.

Top module: `semiring_outer_acc`

## Requirements
- R1: After reset every accumulator is 0, the latched semiring is multiply-add, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted clear command (`in_cmd`=01) sets all accumulators to 0 and latches `in_mode` as the semiring.
- R3: An accepted prime command (`in_cmd`=10) latches `in_mode` and loads every accumulator with the reduce identity of that mode: 0 for multiply-add (`in_mode`=00), +32767 (the largest signed value) for min-plus (01), -32768 (the smallest signed value) for max-plus (10), and 0 for and-or (11).
- R4: In multiply-add mode an update (`in_cmd`=00) sets acc(i,j) to acc(i,j) + col[i]*row[j]. Element k of `in_col`, `in_row` and `out_data` occupies bits [k*DW +: DW].
- R5: In min-plus mode an update sets acc(i,j) to min(acc(i,j), col[i]+row[j]).
- R6: In max-plus mode an update sets acc(i,j) to max(acc(i,j), col[i]+row[j]).
- R7: In and-or mode an update sets acc(i,j) to 1 if acc(i,j) is nonzero or both col[i] and row[j] are nonzero, and to 0 otherwise. Accumulators hold only 0 or 1 in this mode.
- R8: Every product and every sum in the plus-based and multiply-add modes saturates at the signed limits of DW bits and never wraps.
- R9: `in_mode` is ignored on update commands. Updates always use the semiring latched by the last clear or prime.
- R10: An update accepted in one cycle is visible from the next cycle on. A read accepted in that next cycle returns the updated values. Accumulators do not change in a cycle in which no command is accepted.
- R11: A read command (`in_cmd`=11) produces N beats carrying rows 0 to N-1 in order, with `out_last` high only on row N-1.
- R12: While a readout is in flight `in_ready` is 0 and no command is taken. A beat stalled by `out_ready`=0 keeps `out_data` and `out_last` stable.
- R13: Consecutive updates accumulate, so k updates give the rank-k result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command accepted when high together with in_valid |
| in_cmd | input | 2 | 00 update, 01 clear, 10 prime, 11 read |
| in_mode | input | 2 | Semiring for clear/prime: 00 mul-add, 01 min-plus, 10 max-plus, 11 and-or |
| in_col | input | N*DW | Column vector, element i drives tile row i |
| in_row | input | N*DW | Row vector, element j drives tile column j |
| out_valid | output | 1 | Readout beat valid |
| out_ready | input | 1 | Readout beat consumed when high with out_valid |
| out_data | output | N*DW | One tile row, element j at bits [j*DW +: DW] |
| out_last | output | 1 | High on the final row of a readout |

## Verification
The bench pushes products and sums past both signed limits. A datapath that wraps would show a huge product turning negative, or min-plus infinity becoming a very negative number. It sends an update with a different `in_mode` than the latched one, and a design that switches semiring on updates would give multiply-add results in a min-plus tile. It reads on the cycle right after an update, where an extra pipeline stage would return stale rows. It also stalls a readout while offering a clear: a block that accepted the clear would return zeros on the following read, and one that advanced on a stall would skip row 0.

// File: rtl/semiring_pkg.sv
`timescale 1ns/1ps
package semiring_pkg;

  typedef enum logic [1:0] {
    SR_MULADD  = 2'b00,
    SR_MINPLUS = 2'b01,
    SR_MAXPLUS = 2'b10,
    SR_ANDOR   = 2'b11
  } sr_mode_e;

  typedef enum logic [1:0] {
    CMD_UPDATE = 2'b00,
    CMD_CLEAR  = 2'b01,
    CMD_PRIME  = 2'b10,
    CMD_READ   = 2'b11
  } sr_cmd_e;

endpackage

// File: rtl/sr_cell.sv
`timescale 1ns/1ps
module sr_cell
  import semiring_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  sr_mode_e      mode,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] acc
);

  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] clamp_sum(input logic [DW:0] v);
    if (v[DW] != v[DW-1]) return v[DW] ? SMIN : SMAX;
    return v[DW-1:0];
  endfunction

  logic [DW:0]     sum_ab;
  logic [2*DW-1:0] prod_w;
  logic [DW-1:0]   prod_sat;
  logic [DW-1:0]   term;
  logic [DW:0]     acc_plus;
  logic            term_lt;
  logic [DW-1:0]   acc_next;

  always_comb begin
    sum_ab = {a[DW-1], a} + {b[DW-1], b};
    prod_w = {{DW{a[DW-1]}}, a} * {{DW{b[DW-1]}}, b};
    // no overflow when the top DW+1 bits agree
    if ((&prod_w[2*DW-1:DW-1]) || !(|prod_w[2*DW-1:DW-1]))
      prod_sat = prod_w[DW-1:0];
    else
      prod_sat = prod_w[2*DW-1] ? SMIN : SMAX;

    unique case (mode)
      SR_MULADD: term = prod_sat;
      SR_ANDOR:  term = {{(DW-1){1'b0}}, (|a) & (|b)};
      default:   term = clamp_sum(sum_ab);
    endcase

    acc_plus = {acc[DW-1], acc} + {term[DW-1], term};
    term_lt  = $signed(term) < $signed(acc);

    unique case (mode)
      SR_MULADD:  acc_next = clamp_sum(acc_plus);
      SR_MINPLUS: acc_next = term_lt ? term : acc;
      SR_MAXPLUS: acc_next = term_lt ? acc : term;
      default:    acc_next = {{(DW-1){1'b0}}, (|acc) | term[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (load_en) acc <= load_val;
    else if (upd_en)  acc <= acc_next;
  end

endmodule

// File: rtl/sr_ctrl.sv
`timescale 1ns/1ps
module sr_ctrl
  import semiring_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_cmd,
  input  logic [1:0]    in_mode,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [RW-1:0] row_sel,
  output logic          upd_en,
  output logic          load_en,
  output logic [DW-1:0] load_val,
  output sr_mode_e      mode_q
);

  localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic    reading_q;
  logic    fire;
  sr_cmd_e cmd;

  assign in_ready  = !reading_q;
  assign fire      = in_valid && in_ready;
  assign cmd       = sr_cmd_e'(in_cmd);
  assign upd_en    = fire && (cmd == CMD_UPDATE);
  assign load_en   = fire && ((cmd == CMD_CLEAR) || (cmd == CMD_PRIME));
  assign out_valid = reading_q;
  assign out_last  = reading_q && (row_sel == LAST_ROW);

  always_comb begin
    load_val = '0;
    if (cmd == CMD_PRIME) begin
      unique case (sr_mode_e'(in_mode))
        SR_MINPLUS: load_val = SMAX;
        SR_MAXPLUS: load_val = SMIN;
        default:    load_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= SR_MULADD;
      reading_q <= 1'b0;
      row_sel   <= '0;
    end else begin
      if (load_en) mode_q <= sr_mode_e'(in_mode);
      if (fire && (cmd == CMD_READ)) begin
        reading_q <= 1'b1;
        row_sel   <= '0;
      end else if (reading_q && out_ready) begin
        if (row_sel == LAST_ROW) reading_q <= 1'b0;
        else                     row_sel   <= row_sel + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sr_row_mux.sv
`timescale 1ns/1ps
module sr_row_mux #(
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N*DW-1:0] acc_flat,
  input  logic [RW-1:0]     row_sel,
  output logic [N*DW-1:0]   row_data
);

  always_comb begin
    row_data = '0;
    for (int r = 0; r < N; r++) begin
      if (row_sel == RW'(r)) row_data = acc_flat[r*N*DW +: N*DW];
    end
  end

endmodule

// File: rtl/semiring_outer_acc.sv
`timescale 1ns/1ps
module semiring_outer_acc
  import semiring_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_cmd,
  input  logic [1:0]      in_mode,
  input  logic [N*DW-1:0] in_col,
  input  logic [N*DW-1:0] in_row,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*DW-1:0] out_data,
  output logic            out_last
);

  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic [N*N*DW-1:0] acc_flat;
  logic [RW-1:0]     row_sel;
  logic              upd_en;
  logic              load_en;
  logic [DW-1:0]     load_val;
  sr_mode_e          mode_q;

  sr_ctrl #(.N(N), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cmd    (in_cmd),
    .in_mode   (in_mode),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .row_sel   (row_sel),
    .upd_en    (upd_en),
    .load_en   (load_en),
    .load_val  (load_val),
    .mode_q    (mode_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      sr_cell #(.DW(DW)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .load_en  (load_en),
        .load_val (load_val),
        .mode     (mode_q),
        .a        (in_col[i*DW +: DW]),
        .b        (in_row[j*DW +: DW]),
        .acc      (acc_flat[(i*N + j)*DW +: DW])
      );
    end
  end

  sr_row_mux #(.N(N), .DW(DW)) u_mux (
    .acc_flat (acc_flat),
    .row_sel  (row_sel),
    .row_data (out_data)
  );

endmodule

// File: rtl/sr_checker.sv
`timescale 1ns/1ps
module sr_checker #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_cmd,
  input logic              out_valid,
  input logic              out_ready,
  input logic [N*DW-1:0]   out_data,
  input logic              out_last,
  input logic [N*N*DW-1:0] acc_flat,
  input logic [1:0]        mode_q
);

  logic take;
  assign take = in_valid && in_ready;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R12
  AST_NO_TAKE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R12
  AST_READ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cmd == 2'b11) |=> (out_valid && !out_last)); // R11
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid); // R11
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cmd == 2'b01) |=> (acc_flat == '0)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(acc_flat)); // R10
  AST_UPDATE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_cmd == 2'b00) |=> $stable(mode_q)); // R9

  for (genvar k = 0; k < N*N; k++) begin : g_bool
    AST_BOOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b11) |-> (acc_flat[k*DW +: DW] <= 1)); // R7
  end

endmodule

bind semiring_outer_acc sr_checker #(.N(N), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_cmd    (in_cmd),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .acc_flat  (acc_flat),
  .mode_q    (mode_q)
);

// File: tb/test_semiring_outer_acc.sv
`timescale 1ns/1ps
module test_semiring_outer_acc;

  localparam int N  = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_cmd = 2'b00;
  logic [1:0]    in_mode = 2'b00;
  logic [63:0]   in_col = '0;
  logic [63:0]   in_row = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [63:0]   out_data;
  logic          out_last;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_acc [4][4];
  int mdl_mode = 0;

  always #4 clk = ~clk;

  semiring_outer_acc #(.N(N), .DW(DW)) i_semiring_outer_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_mode(in_mode), .in_col(in_col), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  function automatic int sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic logic [63:0] pk(int e0, int e1, int e2, int e3);
    return {e3[15:0], e2[15:0], e1[15:0], e0[15:0]};
  endfunction

  function automatic int el(logic [63:0] v, int k);
    logic signed [15:0] s;
    s = v[k*16 +: 16];
    return int'(s);
  endfunction

  task automatic check(string req, int act, int expv, string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic issue(logic [1:0] cmd, logic [1:0] md, logic [63:0] c, logic [63:0] r);
    in_cmd = cmd; in_mode = md; in_col = c; in_row = r; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clear(int md);
    issue(2'b01, md[1:0], '0, '0);
    mdl_mode = md;
    foreach (exp_acc[i, j]) exp_acc[i][j] = 0;
  endtask

  task automatic do_prime(int md);
    int idv;
    issue(2'b10, md[1:0], '0, '0);
    mdl_mode = md;
    idv = (md == 1) ? 32767 : (md == 2) ? -32768 : 0;
    foreach (exp_acc[i, j]) exp_acc[i][j] = idv;
  endtask

  task automatic do_update(int md_field, logic [63:0] c, logic [63:0] r);
    issue(2'b00, md_field[1:0], c, r);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int a = el(c, i);
        int b = el(r, j);
        int s = sat16(longint'(a) + longint'(b));
        case (mdl_mode)
          0: exp_acc[i][j] = sat16(longint'(exp_acc[i][j]) + longint'(sat16(longint'(a) * longint'(b))));
          1: if (s < exp_acc[i][j]) exp_acc[i][j] = s;
          2: if (s > exp_acc[i][j]) exp_acc[i][j] = s;
          default: exp_acc[i][j] = ((exp_acc[i][j] != 0) || (a != 0 && b != 0)) ? 1 : 0;
        endcase
      end
    end
  endtask

  // consume N beats with out_ready high; caller stands at a negedge with a read in flight
  task automatic drain_rows(string req);
    for (int r = 0; r < 4; r++) begin
      check("R11", int'(out_valid), 1, $sformatf("out_valid row %0d", r));
      check("R11", int'(out_last), (r == 3) ? 1 : 0, $sformatf("out_last row %0d", r));
      for (int j = 0; j < 4; j++)
        check(req, el(out_data, j), exp_acc[r][j], $sformatf("acc(%0d,%0d)", r, j));
      @(posedge clk);
      @(negedge clk);
    end
    check("R11", int'(out_valid), 0, "out_valid after last row");
    check("R12", int'(in_ready), 1, "in_ready after readout");
  endtask

  task automatic read_tile(string req);
    issue(2'b11, 2'b00, '0, '0);
    drain_rows(req);
  endtask

  task automatic t_reset;
    check("R1", int'(out_valid), 0, "out_valid at reset");
    check("R1", int'(in_ready), 1, "in_ready at reset");
    read_tile("R1");
    // mode after reset is multiply-add
    do_update(3, pk(2, 3, 0, -1), pk(4, 5, 6, 7));
    read_tile("R1");
  endtask

  task automatic t_muladd_rank3;
    do_clear(0);
    do_update(0, pk(1, 2, 3, 4),     pk(5, 6, 7, 8));
    do_update(0, pk(-1, 0, 2, -3),   pk(2, -4, 1, 10));
    do_update(0, pk(100, -50, 7, 0), pk(3, 3, -2, 1));
    read_tile("R4 R13");
  endtask

  task automatic t_prime_all;
    for (int m = 0; m < 4; m++) begin
      do_prime(m);
      read_tile("R3");
    end
  endtask

  task automatic t_clear_after_data;
    do_clear(0);
    do_update(0, pk(9, 9, 9, 9), pk(9, 9, 9, 9));
    do_clear(2);
    read_tile("R2");
  endtask

  task automatic t_minplus;
    do_prime(1);
    do_update(1, pk(4, -2, 10, 0), pk(1, 5, -3, 2));
    do_update(1, pk(0, 0, 0, 0),   pk(3, 3, 3, 3));
    read_tile("R5");
  endtask

  task automatic t_maxplus;
    do_prime(2);
    do_update(2, pk(4, -2, 10, 0), pk(1, 5, -3, 2));
    do_update(2, pk(-9, 1, 1, 20), pk(0, 0, 7, -30));
    read_tile("R6");
  endtask

  task automatic t_bool;
    do_prime(3);
    do_update(3, pk(5, 0, -1, 0), pk(0, 7, 1, -2));
    read_tile("R7");
    do_update(3, pk(0, 1, 0, 0), pk(1, 1, 1, 1));
    read_tile("R7");
  endtask

  task automatic t_saturate;
    do_clear(0);
    do_update(0, pk(300, -300, 200, 1), pk(300, 300, -200, 1));
    do_update(0, pk(1, -1, 1, 0), pk(1, 1, -1, 0));
    read_tile("R8");
    do_prime(1);
    do_update(1, pk(32767, -32768, 10, 0), pk(100, -100, 5, 0));
    read_tile("R8");
    do_prime(2);
    do_update(2, pk(-32768, 32767, 0, -5), pk(-5, 50, 0, -5));
    read_tile("R8");
  endtask

  task automatic t_mode_ignored;
    do_prime(1);
    do_update(0, pk(3, 8, -4, 1), pk(2, 2, 0, 9));
    read_tile("R9");
  endtask

  task automatic t_back_to_back;
    do_clear(0);
    do_update(0, pk(1, 1, 1, 1), pk(1, 2, 3, 4));
    do_update(0, pk(2, 0, -1, 5), pk(6, 6, 6, 6));
    // read accepted in the cycle right after the last update
    read_tile("R10");
  endtask

  task automatic t_backpressure;
    do_clear(0);
    do_update(0, pk(1, 2, 3, 4), pk(10, 20, 30, 40));
    out_ready = 1'b0;
    issue(2'b11, 2'b00, '0, '0);
    // offer a clear while the first beat is stalled
    in_cmd = 2'b01; in_mode = 2'b00; in_valid = 1'b1;
    for (int s = 0; s < 3; s++) begin
      check("R12", int'(out_valid), 1, "out_valid while stalled");
      check("R12", int'(in_ready), 0, "in_ready while stalled");
      check("R12", int'(out_last), 0, "out_last while stalled");
      for (int j = 0; j < 4; j++)
        check("R12", el(out_data, j), exp_acc[0][j], $sformatf("stalled row0 elem %0d", j));
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    drain_rows("R12");
    read_tile("R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_muladd_rank3();
    t_prime_all();
    t_clear_after_data();
    t_minplus();
    t_maxplus();
    t_bool();
    t_saturate();
    t_mode_ignored();
    t_back_to_back();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule